// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a behavioural model of a synchronous burst static memory with a small internal array. It is intended as a memory stand-in beside a processor or memory controller. Every rising clock edge, it decodes three chip enables, two address strobes, a burst-advance input and the write controls into one cycle operation:

- deselect
- begin read
- begin write
- continue read
- continue write
- suspend read
- suspend write
- asleep

A burst covers four beats inside an aligned group of four addresses. A two-bit beat counter runs either a linear (wrapping add) or an interleaved (XOR) order over the low address bits.

The processor-side strobe always starts a read at the external address. It does so even when the write controls are active. Writes begin only through the controller-side strobe, or through continue and suspend cycles that follow.

Read data use flow-through timing. The array word at the address captured on an edge is presented until the next edge, and the output enable gates it combinationally.

A sleep request takes the block through a two-cycle entry and a two-cycle exit. During the asleep cycles, every access is discarded.

Three state machines carry the behaviour:

- **Power machine.** Its states are RUN, DOZE, SLEEP and WAKE.
  - RUN goes to DOZE when the request is high.
  - DOZE goes to SLEEP when the request is high, or back to RUN when it is low.
  - SLEEP goes to WAKE when the request is low.
  - WAKE goes to RUN when the request is low, or back to SLEEP when it is high.
- **Bus machine.** Its states are IDLE, READ and WRITE. Every edge it moves to READ after a read operation, to WRITE after a write operation, and to IDLE after a deselect or asleep cycle.
- **Burst sequencer.** A begin operation loads the base address, clears the beat count and latches the order mode. A continue operation increments the count. A suspend operation holds it.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected when en_a_n=0, en_b=1 and en_c_n=0. A deselect cycle occurs in two cases: strobe_p_n=0 with en_a_n=0 while not selected, or strobe_p_n ignored (en_a_n=1 or strobe_p_n=1) with strobe_c_n=0 while not selected. A deselect touches no memory, and the next cycle does not drive. With en_a_n=1, strobe_p_n is ignored, so with strobe_c_n=1 the cycle continues or suspends.
- R2: strobe_p_n=0 with the chip selected begins a read at addr, whatever wr_global_n, wr_bytes_n and lane_n are, and leaves the array unchanged.
- R3: strobe_p_n ignored, strobe_c_n=0 and chip selected begins an access at addr. It is a write when the internal write signal is active, and a read otherwise.
- R4: Both strobes inactive and burst_step_n=0 continue at the next burst address. With burst_step_n=1 the cycle suspends at the current address. Neither case needs the chip enables. Each is a write when the internal write signal is active, and a read otherwise.
- R5: Beat n (0..3) of a burst that starts at address S keeps S[7:2]. Its low two bits are (S[1:0]+n) mod 4 when order_linear was 1 on the begin cycle, and S[1:0] XOR n when it was 0. A fifth beat wraps to the start.
- R6: The internal write signal is active when wr_global_n=0, or when wr_bytes_n=0 and some lane_n bit is 0. wr_global_n=0 writes both lanes. Otherwise lane i (data bits 8i+7..8i) is written only where lane_n[i]=0.
- R7: After a read cycle, dq_out shows the word at that cycle's address until the next edge, and dq_drive is 1 whenever out_en_n=0. out_en_n acts without a clock. After a write, deselect or asleep cycle, dq_drive is 0. dq_out is 0 whenever dq_drive is 0.
- R8: Accesses are still performed on the first two edges at which sleep_req is 1. From the third such edge on, they are discarded and dq_drive drops. After sleep_req returns to 0, accesses on the first two edges are discarded, and the third edge is performed normally.
- R9: While rst_n is 0, dq_drive is 0 and dq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_a_n | input | 1 | Chip enable A, active low; also gates strobe_p_n |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| wr_global_n | input | 1 | Write all lanes, active low |
| wr_bytes_n | input | 1 | Byte write enable, active low |
| lane_n | input | 2 | Per-lane write enables, active low |
| order_linear | input | 1 | Burst order, 1 linear, 0 interleaved; latched on begin |
| sleep_req | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Output enable, active low, combinational |
| addr | input | 8 | External address |
| wdata | input | 16 | Write data, used in the write cycle |
| dq_out | output | 16 | Read data, zero when not driving |
| dq_drive | output | 1 | High while dq_out is driven |

## Verification
The bench writes four-beat bursts that mix in a suspend which overwrites a beat. It reads them back in bursts, then reads single words at absolute addresses. A sequencer with a wrong order or a wrong wrap would put words at the wrong addresses.

A processor-strobe cycle with the write controls active must leave the array untouched. A decoder that let it write would corrupt that word.

The strobe_p_n case with en_a_n=1 must continue the burst, not deselect. A design that failed this would stop driving.

The sleep sequence writes on each edge around entry and exit. An off-by-one in the power machine would keep or lose the wrong words. Constrained random traffic against a bench reference model covers the remaining mixes, including toggling out_en_n between edges.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_DESEL,
        OP_BEGIN_RD,
        OP_BEGIN_WR,
        OP_CONT_RD,
        OP_CONT_WR,
        OP_SUSP_RD,
        OP_SUSP_WR,
        OP_ASLEEP
    } cyc_op_e;

    typedef enum logic [1:0] {
        PW_RUN,
        PW_DOZE,
        PW_SLEEP,
        PW_WAKE
    } pwr_e;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_READ,
        BS_WRITE
    } bus_e;

    // low two address bits of beat n for a burst starting at start
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       lin);
        logic [1:0] r;
        if (lin) r = start + n;
        else     r = start ^ n;
        return r;
    endfunction

    function automatic logic op_is_write(input cyc_op_e op);
        return (op == OP_BEGIN_WR) || (op == OP_CONT_WR) || (op == OP_SUSP_WR);
    endfunction

    function automatic logic op_is_read(input cyc_op_e op);
        return (op == OP_BEGIN_RD) || (op == OP_CONT_RD) || (op == OP_SUSP_RD);
    endfunction

endpackage

// File: rtl/sbs_power_fsm.sv
`timescale 1ns/1ps
module sbs_power_fsm
    import sbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic awake
);

    pwr_e state_q;
    pwr_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_RUN:   state_d = sleep_req ? PW_DOZE  : PW_RUN;
            PW_DOZE:  state_d = sleep_req ? PW_SLEEP : PW_RUN;
            PW_SLEEP: state_d = sleep_req ? PW_SLEEP : PW_WAKE;
            PW_WAKE:  state_d = sleep_req ? PW_SLEEP : PW_RUN;
            default:  state_d = PW_RUN;
        endcase
    end

    always_comb begin
        awake = (state_q == PW_RUN) || (state_q == PW_DOZE);
    end

    // R8: sleep is never reached in a single edge from run
    p_two_edge_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_RUN) |=> (state_q != PW_SLEEP));

    // R8: sleep only leaves through the wake state
    p_exit_via_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_SLEEP) |=> (state_q == PW_SLEEP || state_q == PW_WAKE));

endmodule

// File: rtl/sbs_decode.sv
`timescale 1ns/1ps
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          en_a_n,
    input  logic          en_b,
    input  logic          en_c_n,
    input  logic          strobe_p_n,
    input  logic          strobe_c_n,
    input  logic          burst_step_n,
    input  logic          wr_global_n,
    input  logic          wr_bytes_n,
    input  logic [NB-1:0] lane_n,
    input  logic          awake,
    output cyc_op_e       op,
    output logic [NB-1:0] lane_mask
);

    logic selected;
    logic wr_req;
    logic p_strobe;

    always_comb begin
        selected  = !en_a_n && en_b && !en_c_n;
        wr_req    = !wr_global_n || (!wr_bytes_n && !(&lane_n));
        p_strobe  = !strobe_p_n && !en_a_n;
        if (!wr_global_n)     lane_mask = '1;
        else if (!wr_bytes_n) lane_mask = ~lane_n;
        else                  lane_mask = '0;
    end

    always_comb begin
        if (!awake)
            op = OP_ASLEEP;
        else if (p_strobe)
            op = selected ? OP_BEGIN_RD : OP_DESEL;
        else if (!strobe_c_n)
            op = selected ? (wr_req ? OP_BEGIN_WR : OP_BEGIN_RD) : OP_DESEL;
        else if (!burst_step_n)
            op = wr_req ? OP_CONT_WR : OP_CONT_RD;
        else
            op = wr_req ? OP_SUSP_WR : OP_SUSP_RD;
    end

endmodule

// File: rtl/sbs_burst_seq.sv
`timescale 1ns/1ps
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_op_e       op,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_linear,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] cur_addr
);

    localparam int HI = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          lin_q;
    logic [1:0]    next_low;

    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, lin_q)};
        next_low = burst_low(base_q[1:0], cnt_q + 2'd1, lin_q);
        unique case (op)
            OP_BEGIN_RD, OP_BEGIN_WR: acc_addr = ext_addr;
            OP_CONT_RD,  OP_CONT_WR:  acc_addr = {base_q[AW-1:2], next_low};
            default:                  acc_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b1;
        end else begin
            unique case (op)
                OP_BEGIN_RD, OP_BEGIN_WR: begin
                    base_q <= ext_addr;
                    cnt_q  <= '0;
                    lin_q  <= order_linear;
                end
                OP_CONT_RD, OP_CONT_WR: cnt_q <= cnt_q + 2'd1;
                default: ;
            endcase
        end
    end

    // R3: a begin cycle makes the external address current
    p_begin_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BEGIN_RD || op == OP_BEGIN_WR) |=> (cur_addr == $past(ext_addr)));

    // R4: suspend holds the burst address
    p_suspend_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUSP_RD || op == OP_SUSP_WR) |=> $stable(cur_addr));

    // R5: continue never leaves the aligned group of four
    p_group_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CONT_RD || op == OP_CONT_WR) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    logic [HI-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    we_mask,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_mask[g]) mem[waddr] <= wdata[g*BW +: BW];
        end

        assign rdata[g*BW +: BW] = mem[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 8,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_a_n,
    input  logic          en_b,
    input  logic          en_c_n,
    input  logic          strobe_p_n,
    input  logic          strobe_c_n,
    input  logic          burst_step_n,
    input  logic          wr_global_n,
    input  logic          wr_bytes_n,
    input  logic [NB-1:0] lane_n,
    input  logic          order_linear,
    input  logic          sleep_req,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dq_out,
    output logic          dq_drive
);

    logic          awake;
    cyc_op_e       op;
    logic [NB-1:0] lane_mask;
    logic [NB-1:0] we_mask;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] arr_rdata;
    bus_e          bus_q;
    bus_e          bus_d;

    sbs_power_fsm u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .awake     (awake)
    );

    sbs_decode #(.NB(NB)) u_decode (
        .en_a_n       (en_a_n),
        .en_b         (en_b),
        .en_c_n       (en_c_n),
        .strobe_p_n   (strobe_p_n),
        .strobe_c_n   (strobe_c_n),
        .burst_step_n (burst_step_n),
        .wr_global_n  (wr_global_n),
        .wr_bytes_n   (wr_bytes_n),
        .lane_n       (lane_n),
        .awake        (awake),
        .op           (op),
        .lane_mask    (lane_mask)
    );

    sbs_burst_seq #(.AW(AW)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .ext_addr     (addr),
        .order_linear (order_linear),
        .acc_addr     (acc_addr),
        .cur_addr     (cur_addr)
    );

    always_comb begin
        we_mask = op_is_write(op) ? lane_mask : '0;
    end

    sbs_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk     (clk),
        .we_mask (we_mask),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .raddr   (rd_addr_q),
        .rdata   (arr_rdata)
    );

    // bus state: what the last performed cycle was
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q     <= BS_IDLE;
            rd_addr_q <= '0;
        end else begin
            bus_q <= bus_d;
            if (op_is_read(op)) rd_addr_q <= acc_addr;
        end
    end

    always_comb begin
        bus_d = BS_IDLE;
        unique case (op)
            OP_BEGIN_RD, OP_CONT_RD, OP_SUSP_RD: bus_d = BS_READ;
            OP_BEGIN_WR, OP_CONT_WR, OP_SUSP_WR: bus_d = BS_WRITE;
            default:                             bus_d = BS_IDLE;
        endcase
    end

    // outputs: enable is not clocked
    always_comb begin
        dq_drive = (bus_q == BS_READ) && !out_en_n;
        dq_out   = dq_drive ? arr_rdata : '0;
    end

    // R7: a write cycle leaves the bus undriven
    p_write_blanks_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_write(op) |=> !dq_drive);

    // R1: a deselect cycle leaves the bus undriven
    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESEL) |=> !dq_drive);

    // R2: processor strobe on a selected chip always reads
    p_pstrobe_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !strobe_p_n && !en_a_n && en_b && !en_c_n) |=> (dq_drive || out_en_n));

    // R8: asleep cycles leave the bus undriven
    p_asleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> !dq_drive);

    logic [AW-1:0] unused_cur;
    assign unused_cur = cur_addr;

endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic        strobe_p_n = 1'b1, strobe_c_n = 1'b1, burst_step_n = 1'b1;
    logic        wr_global_n = 1'b1, wr_bytes_n = 1'b1;
    logic [1:0]  lane_n = 2'b11;
    logic        order_linear = 1'b1, sleep_req = 1'b0, out_en_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] dq_out;
    logic        dq_drive;

    always #2 clk = ~clk;

    sync_burst_sram i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .burst_step_n(burst_step_n),
        .wr_global_n(wr_global_n), .wr_bytes_n(wr_bytes_n), .lane_n(lane_n),
        .order_linear(order_linear), .sleep_req(sleep_req), .out_en_n(out_en_n),
        .addr(addr), .wdata(wdata), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_tag = "R7";

    // reference model state
    logic [15:0] mm [256];
    logic [7:0]  mbase = '0;
    logic [1:0]  mcnt = '0;
    logic        mlin = 1'b1;
    int          mbus = 0;   // 0 idle, 1 read, 2 write
    logic [7:0]  mraddr = '0;
    int          mpw = 0;    // 0 run, 1 doze, 2 sleep, 3 wake

    function automatic logic [15:0] fill(input logic [7:0] a);
        return {a, a} ^ 16'h5a3c;
    endfunction

    function automatic logic [1:0] lowf(input logic [1:0] s, input logic [1:0] n, input logic lin);
        logic [1:0] r;
        r = lin ? s + n : s ^ n;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic awake, sel, wr;
        logic [1:0] lm;
        logic [7:0] ua;
        int op; // 0 desel 1 brd 2 bwr 3 crd 4 cwr 5 srd 6 swr 7 asleep
        awake = (mpw == 0) || (mpw == 1);
        sel = !en_a_n && en_b && !en_c_n;
        wr = !wr_global_n || (!wr_bytes_n && lane_n != 2'b11);
        lm = !wr_global_n ? 2'b11 : (!wr_bytes_n ? ~lane_n : 2'b00);
        if (!awake) op = 7;
        else if (!strobe_p_n && !en_a_n) op = sel ? 1 : 0;
        else if (!strobe_c_n) op = sel ? (wr ? 2 : 1) : 0;
        else if (!burst_step_n) op = wr ? 4 : 3;
        else op = wr ? 6 : 5;
        ua = {mbase[7:2], lowf(mbase[1:0], mcnt, mlin)};
        if (op == 1 || op == 2) begin
            ua = addr; mbase = addr; mcnt = 2'd0; mlin = order_linear;
        end else if (op == 3 || op == 4) begin
            mcnt = mcnt + 2'd1;
            ua = {mbase[7:2], lowf(mbase[1:0], mcnt, mlin)};
        end
        if (op == 2 || op == 4 || op == 6) begin
            if (lm[0]) mm[ua][7:0]  = wdata[7:0];
            if (lm[1]) mm[ua][15:8] = wdata[15:8];
            mbus = 2;
        end else if (op == 1 || op == 3 || op == 5) begin
            mbus = 1; mraddr = ua;
        end else mbus = 0;
        case (mpw)
            0: mpw = sleep_req ? 1 : 0;
            1: mpw = sleep_req ? 2 : 0;
            2: mpw = sleep_req ? 2 : 3;
            default: mpw = sleep_req ? 2 : 0;
        endcase
    endtask

    // one clock: model update at the edge, outputs compared just after
    task automatic step();
        logic exp_drive;
        @(posedge clk);
        model_step();
        #1;
        exp_drive = (mbus == 1) && !out_en_n;
        chk({cur_tag, " drive"}, {15'd0, dq_drive}, {15'd0, exp_drive});
        chk({cur_tag, " data"}, dq_out, exp_drive ? mm[mraddr] : 16'h0000);
    endtask

    task automatic quiet();
        en_a_n = 0; en_b = 1; en_c_n = 0;
        strobe_p_n = 1; strobe_c_n = 1; burst_step_n = 1;
        wr_global_n = 1; wr_bytes_n = 1; lane_n = 2'b11;
    endtask

    task automatic wr_c(input logic [7:0] a, input logic [15:0] d, input logic lin);
        @(negedge clk); quiet();
        strobe_c_n = 0; wr_global_n = 0; addr = a; wdata = d; order_linear = lin;
        step();
    endtask

    task automatic wr_next(input logic [15:0] d);
        @(negedge clk); quiet();
        burst_step_n = 0; wr_global_n = 0; wdata = d;
        step();
    endtask

    task automatic wr_susp(input logic [15:0] d);
        @(negedge clk); quiet();
        wr_global_n = 0; wdata = d;
        step();
    endtask

    task automatic rd_p(input logic [7:0] a, input logic lin, input logic wctl);
        @(negedge clk); quiet();
        strobe_p_n = 0; addr = a; order_linear = lin;
        if (wctl) begin wr_global_n = 0; wr_bytes_n = 0; lane_n = 2'b00; wdata = 16'hdead; end
        step();
    endtask

    task automatic rd_next();
        @(negedge clk); quiet(); burst_step_n = 0; step();
    endtask

    task automatic rd_susp();
        @(negedge clk); quiet(); step();
    endtask

    task automatic burst_case(input logic [7:0] s, input logic lin, input string tag);
        logic [15:0] d [4];
        logic [7:0] ba;
        for (int k = 0; k < 4; k++) d[k] = {s, 8'(k)} ^ 16'h3c00;
        cur_tag = tag;
        wr_c(s, d[0], lin);
        wr_next(16'h0bad);
        wr_susp(d[1]);          // suspend overwrites beat 1
        wr_next(d[2]);
        wr_next(d[3]);
        rd_p(s, lin, 1'b0);    chk({tag, " beat0"}, dq_out, d[0]);
        rd_next();             chk({tag, " beat1"}, dq_out, d[1]);
        rd_susp();             chk({tag, " R4 suspend"}, dq_out, d[1]);
        rd_next();             chk({tag, " beat2"}, dq_out, d[2]);
        rd_next();             chk({tag, " beat3"}, dq_out, d[3]);
        rd_next();             chk({tag, " wrap"}, dq_out, d[0]);
        for (int k = 1; k < 4; k++) begin
            ba = {s[7:2], lin ? 2'(s[1:0] + 2'(k)) : 2'(s[1:0] ^ 2'(k))};
            rd_p(ba, 1'b1, 1'b0);
            chk({tag, " placed"}, dq_out, d[k]);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        #5;
        chk("R9 reset drive", {15'd0, dq_drive}, 16'd0);
        chk("R9 reset data", dq_out, 16'd0);
        @(negedge clk); rst_n = 1;

        cur_tag = "R3";
        for (int i = 0; i < 256; i++) wr_c(8'(i), fill(8'(i)), 1'b1);

        burst_case(8'h12, 1'b1, "R5 linear");
        burst_case(8'h25, 1'b0, "R5 interleaved");
        burst_case(8'h6b, 1'b0, "R5 interleaved3");

        // R2: write controls ignored under processor strobe
        cur_tag = "R2";
        rd_p(8'h41, 1'b1, 1'b1);
        chk("R2 read not write", dq_out, fill(8'h41));
        chk("R2 drives", {15'd0, dq_drive}, 16'd1);

        // R1: en_a_n high masks strobe_p_n, so the cycle continues
        cur_tag = "R1";
        @(negedge clk); quiet(); en_a_n = 1; strobe_p_n = 0; burst_step_n = 0; step();
        chk("R1 masked strobe continues", dq_out, fill(8'h42));
        @(negedge clk); quiet(); en_b = 0; strobe_c_n = 0; wr_global_n = 0; addr = 8'h50; wdata = 16'h1111; step();
        chk("R1 deselect no drive", {15'd0, dq_drive}, 16'd0);
        @(negedge clk); quiet(); en_c_n = 1; strobe_p_n = 0; step();
        chk("R1 deselect by p strobe", {15'd0, dq_drive}, 16'd0);
        rd_p(8'h50, 1'b1, 1'b0);
        chk("R1 deselect wrote nothing", dq_out, fill(8'h50));

        // R7: output enable acts between edges
        cur_tag = "R7";
        @(negedge clk); out_en_n = 1; #0.5;
        chk("R7 async disable", {15'd0, dq_drive}, 16'd0);
        chk("R7 zero when off", dq_out, 16'd0);
        out_en_n = 0; #0.5;
        chk("R7 async enable", dq_out, fill(8'h50));
        wr_c(8'h51, 16'h7777, 1'b1);
        chk("R7 write masks enable", {15'd0, dq_drive}, 16'd0);

        // R6: lane gating
        cur_tag = "R6";
        @(negedge clk); quiet(); strobe_c_n = 0; wr_bytes_n = 0; lane_n = 2'b10;
        addr = 8'h60; wdata = 16'hbeef; step();
        rd_p(8'h60, 1'b1, 1'b0);
        chk("R6 lane0 only", dq_out, {fill(8'h60)[15:8], 8'hef});
        @(negedge clk); quiet(); strobe_c_n = 0; wr_bytes_n = 1; lane_n = 2'b00;
        addr = 8'h61; wdata = 16'hbeef; step();
        chk("R6 no byte enable reads", dq_out, fill(8'h61));

        // R8: sleep entry and exit timing
        cur_tag = "R8";
        sleep_req = 1;
        wr_c(8'h70, 16'ha000, 1'b1);
        wr_c(8'h71, 16'ha001, 1'b1);
        wr_c(8'h72, 16'ha002, 1'b1);
        chk("R8 asleep no drive", {15'd0, dq_drive}, 16'd0);
        sleep_req = 0;
        wr_c(8'h73, 16'ha003, 1'b1);
        wr_c(8'h74, 16'ha004, 1'b1);
        wr_c(8'h75, 16'ha005, 1'b1);
        rd_p(8'h70, 1'b1, 1'b0); chk("R8 edge1 kept", dq_out, 16'ha000);
        rd_p(8'h71, 1'b1, 1'b0); chk("R8 edge2 kept", dq_out, 16'ha001);
        rd_p(8'h72, 1'b1, 1'b0); chk("R8 asleep dropped", dq_out, fill(8'h72));
        rd_p(8'h73, 1'b1, 1'b0); chk("R8 exit1 dropped", dq_out, fill(8'h73));
        rd_p(8'h74, 1'b1, 1'b0); chk("R8 exit2 dropped", dq_out, fill(8'h74));
        rd_p(8'h75, 1'b1, 1'b0); chk("R8 resumed", dq_out, 16'ha005);

        // constrained random against the model (R1..R8)
        cur_tag = "R4 random";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            en_a_n       = ($urandom % 8) == 0;
            en_b         = ($urandom % 8) != 0;
            en_c_n       = ($urandom % 8) == 0;
            strobe_p_n   = ($urandom % 6) != 0;
            strobe_c_n   = ($urandom % 5) != 0;
            burst_step_n = ($urandom % 3) == 0;
            wr_global_n  = ($urandom % 4) != 0;
            wr_bytes_n   = ($urandom % 2) != 0;
            lane_n       = 2'($urandom);
            order_linear = 1'($urandom);
            out_en_n     = ($urandom % 8) == 0;
            addr         = 8'($urandom);
            wdata        = 16'($urandom);
            if (($urandom % 64) == 0) sleep_req = ~sleep_req;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule